// File: doc/BRIEF.md
# Per-Channel Drain Fault Monitor

This block watches one low-side output channel. It takes two digitized comparator results from the drain sense node: one that says the drain sits above the short threshold, and one that says it sits below the open-load threshold. It also takes the commanded gate state. From these it detects a load short while the output is driven on, and an open load while the output is off. Each detection needs the comparator to stay asserted without a break for longer than a parameterized filter time.

Once a short is found, the block protects the output with a low-duty-cycle retry pattern. A gate-mask output drops low for a refresh interval. It then rises again for exactly one sense window, so the short can be seen again. The channel returns to normal drive when a sense window passes without a renewed short, or when software commands the channel off.

The per-fault flags and their OR are live: each clears as soon as its condition ends. The gate selector ANDs `gate_mask` with its own gate request. All times are counted in system clock cycles.

Top module: `drain_fault_mon`

## Requirements
- R1: With `gate_cmd`=1 and `drain_hi`=1 for SHORT_FILT+1 consecutive clock edges, `short_flt` and `fault` are 1 and `gate_mask` is 0 after that last edge; after only SHORT_FILT such edges `short_flt` is still 0. With `gate_cmd`=0, `drain_hi` never sets `short_flt`.
- R2: A single cycle with the comparator low (`drain_hi` for shorts, `drain_lo` for open loads) restarts that fault's filter from zero, so a full new run of filter+1 cycles is needed.
- R3: After a short is detected, `gate_mask` stays 0 for exactly REFRESH_OFF cycles and then returns to 1.
- R4: In a retry, `gate_mask` is 1 for SHORT_FILT+1 cycles. If `drain_hi` stays 1 through that window, the short is detected again: `gate_mask` drops to 0 and `short_flt` stays 1.
- R5: If `drain_hi` is 0 in at least one cycle of a retry window, `short_flt` clears to 0 at the end of that window (SHORT_FILT+1 cycles after it began), and `gate_mask` stays 1.
- R6: Driving `gate_cmd`=0 during the retry pattern ends it at the next edge: `short_flt` becomes 0 and `gate_mask` becomes 1.
- R7: With `gate_cmd`=0 and `drain_lo`=1 for OPEN_FILT+1 consecutive edges, `open_flt` and `fault` are 1 after that last edge; after OPEN_FILT edges `open_flt` is still 0.
- R8: While `gate_cmd`=1 no open load is detected, and an existing `open_flt` clears at the first edge where `gate_cmd` is 1.
- R9: `open_flt` clears at the first edge at which `drain_lo` is 0.
- R10: While `rst_n`=0, `gate_mask`=1 and `short_flt`=`open_flt`=`fault`=0; `fault` is always the OR of `short_flt` and `open_flt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_cmd | input | 1 | Commanded gate state for this channel (1 = on) |
| drain_hi | input | 1 | Drain above short threshold (digitized comparator) |
| drain_lo | input | 1 | Drain below open-load threshold (digitized comparator) |
| gate_mask | output | 1 | 0 while the retry pattern forces the gate off |
| short_flt | output | 1 | Load short present |
| open_flt | output | 1 | Open load present |
| fault | output | 1 | Either fault present |

## Verification
The short path is tried with four `drain_hi` patterns:
- A steady high level, which pins the detection edge exactly, together with the refresh length and the length of the sense window.
- A run that breaks for one cycle just before the filter expires, which separates a restarting filter from one that merely pauses.
- A short that disappears during the refresh, which shows the retry exit at the window end.
- A high level with the gate commanded off, which shows that detection is qualified by the gate.

The open-load path gets similar patterns: a steady low drain, a one-cycle break, and a gate turned on over an open load. Both the threshold crossing and the clearing are checked on their exact cycles. Dropping the command in both the off and the on phase of a retry shows that the pattern ends at once from either state.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
    typedef enum logic [1:0] {
        RS_NORMAL = 2'd0,
        RS_OFF    = 2'd1,
        RS_ON     = 2'd2
    } retry_st_e;
endpackage

// File: rtl/dfm_filter.sv
module dfm_filter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic level,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } flt_s;

    flt_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = level && !clr && (st_q.cnt == CW'(LIMIT));
        if (clr || !level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CW'(LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    filter_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || !level) |=> (st_q.cnt == '0));
endmodule

// File: rtl/dfm_retry_ctl.sv
module dfm_retry_ctl
    import dfm_pkg::*;
#(
    parameter int SHORT_FILT  = 4,
    parameter int REFRESH_OFF = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_cmd,
    input  logic short_hit,
    output logic gate_mask,
    output logic short_flt,
    output logic retry_off
);
    localparam int TMAX = (REFRESH_OFF > SHORT_FILT) ? REFRESH_OFF : SHORT_FILT;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        retry_st_e     st;
        logic [TW-1:0] tmr;
    } rty_s;

    rty_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            RS_NORMAL: begin
                if (short_hit) begin
                    r_d.st  = RS_OFF;
                    r_d.tmr = '0;
                end
            end
            RS_OFF: begin
                if (!gate_cmd) begin
                    r_d.st  = RS_NORMAL;
                    r_d.tmr = '0;
                end else if (r_q.tmr == TW'(REFRESH_OFF - 1)) begin
                    r_d.st  = RS_ON;
                    r_d.tmr = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            RS_ON: begin
                if (!gate_cmd) begin
                    r_d.st  = RS_NORMAL;
                    r_d.tmr = '0;
                end else if (short_hit) begin
                    r_d.st  = RS_OFF;
                    r_d.tmr = '0;
                end else if (r_q.tmr == TW'(SHORT_FILT)) begin
                    r_d.st  = RS_NORMAL;
                    r_d.tmr = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            default: begin
                r_d.st  = RS_NORMAL;
                r_d.tmr = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RS_NORMAL, tmr: '0};
        else        r_q <= r_d;
    end

    assign retry_off = (r_q.st == RS_OFF);
    assign gate_mask = !retry_off;
    assign short_flt = (r_q.st != RS_NORMAL);

    // R3
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RS_OFF && gate_cmd && r_q.tmr != TW'(REFRESH_OFF - 1)) |=> !gate_mask);

    // R6
    cmd_off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_cmd && short_flt) |=> (!short_flt && gate_mask));
endmodule

// File: rtl/drain_fault_mon.sv
module drain_fault_mon #(
    parameter int SHORT_FILT  = 4,
    parameter int REFRESH_OFF = 6,
    parameter int OPEN_FILT   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_cmd,
    input  logic drain_hi,
    input  logic drain_lo,
    output logic gate_mask,
    output logic short_flt,
    output logic open_flt,
    output logic fault
);
    logic short_level, short_hit, retry_off;
    logic open_level, open_hit;
    logic open_d, open_q;

    assign short_level = gate_cmd && gate_mask && drain_hi;
    assign open_level  = !gate_cmd && drain_lo;

    dfm_filter #(.LIMIT(SHORT_FILT)) u_short_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (retry_off),
        .level (short_level),
        .hit   (short_hit)
    );

    dfm_filter #(.LIMIT(OPEN_FILT)) u_open_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .level (open_level),
        .hit   (open_hit)
    );

    dfm_retry_ctl #(
        .SHORT_FILT  (SHORT_FILT),
        .REFRESH_OFF (REFRESH_OFF)
    ) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_cmd  (gate_cmd),
        .short_hit (short_hit),
        .gate_mask (gate_mask),
        .short_flt (short_flt),
        .retry_off (retry_off)
    );

    always_comb begin
        open_d = open_q ? open_level : open_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end

    assign open_flt = open_q;
    assign fault    = short_flt || open_q;

    // R1
    short_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_flt) |-> $past(gate_cmd && drain_hi));

    // R8
    open_on_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_cmd |=> !open_flt);
endmodule

// File: tb/drain_fault_mon_tb.sv
`timescale 1ns/1ps
module drain_fault_mon_tb;
    localparam int SF = 4;
    localparam int RO = 6;
    localparam int OF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_cmd = 1'b0;
    logic drain_hi = 1'b0;
    logic drain_lo = 1'b0;
    logic gate_mask, short_flt, open_flt, fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    drain_fault_mon #(.SHORT_FILT(SF), .REFRESH_OFF(RO), .OPEN_FILT(OF)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_cmd  (gate_cmd),
        .drain_hi  (drain_hi),
        .drain_lo  (drain_lo),
        .gate_mask (gate_mask),
        .short_flt (short_flt),
        .open_flt  (open_flt),
        .fault     (fault)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; gate_cmd = 1'b0; drain_hi = 1'b0; drain_lo = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; gate_cmd = 1'b1; drain_hi = 1'b1; drain_lo = 1'b1;
        step(3);
        chk("R10", "mask in reset", gate_mask, 1'b1);
        chk("R10", "short in reset", short_flt, 1'b0);
        chk("R10", "open in reset", open_flt, 1'b0);
        chk("R10", "fault in reset", fault, 1'b0);
    endtask

    task automatic t_short_retry();
        do_reset();
        gate_cmd = 1'b1; drain_hi = 1'b1;
        step(SF);
        chk("R1", "short before filter end", short_flt, 1'b0);
        chk("R1", "mask before filter end", gate_mask, 1'b1);
        step(1);
        chk("R1", "short at detect", short_flt, 1'b1);
        chk("R1", "fault at detect", fault, 1'b1);
        chk("R1", "mask at detect", gate_mask, 1'b0);
        step(RO - 1);
        chk("R3", "mask at last off cycle", gate_mask, 1'b0);
        step(1);
        chk("R3", "mask after refresh", gate_mask, 1'b1);
        step(SF);
        chk("R4", "mask end of sense window", gate_mask, 1'b1);
        chk("R4", "short in sense window", short_flt, 1'b1);
        step(1);
        chk("R4", "mask after re-detect", gate_mask, 1'b0);
        chk("R4", "short after re-detect", short_flt, 1'b1);
        gate_cmd = 1'b0;
        step(1);
        chk("R6", "short after cmd off in refresh", short_flt, 1'b0);
        chk("R6", "mask after cmd off in refresh", gate_mask, 1'b1);
    endtask

    task automatic t_retry_exit();
        do_reset();
        gate_cmd = 1'b1; drain_hi = 1'b1;
        step(SF + 1);
        chk("R5", "short detected", short_flt, 1'b1);
        drain_hi = 1'b0;
        step(RO);
        chk("R5", "mask window start", gate_mask, 1'b1);
        step(SF);
        chk("R5", "short held to window end", short_flt, 1'b1);
        step(1);
        chk("R5", "short cleared after window", short_flt, 1'b0);
        chk("R5", "mask after exit", gate_mask, 1'b1);
        chk("R10", "fault follows short", fault, 1'b0);
    endtask

    task automatic t_cmd_off_on();
        do_reset();
        gate_cmd = 1'b1; drain_hi = 1'b1;
        step(SF + 1 + RO + 1);
        chk("R6", "in sense window", gate_mask, 1'b1);
        gate_cmd = 1'b0;
        step(1);
        chk("R6", "short after cmd off in window", short_flt, 1'b0);
        chk("R6", "mask after cmd off in window", gate_mask, 1'b1);
    endtask

    task automatic t_short_glitch();
        do_reset();
        gate_cmd = 1'b1; drain_hi = 1'b1;
        step(SF);
        drain_hi = 1'b0;
        step(1);
        drain_hi = 1'b1;
        step(SF);
        chk("R2", "short after broken run", short_flt, 1'b0);
        step(1);
        chk("R2", "short after full run", short_flt, 1'b1);
    endtask

    task automatic t_short_gate_off();
        do_reset();
        gate_cmd = 1'b0; drain_hi = 1'b1;
        step(20);
        chk("R1", "no short with gate off", short_flt, 1'b0);
        chk("R1", "no fault with gate off", fault, 1'b0);
    endtask

    task automatic t_open();
        do_reset();
        gate_cmd = 1'b0; drain_lo = 1'b1;
        step(OF);
        chk("R7", "open before filter end", open_flt, 1'b0);
        step(1);
        chk("R7", "open at detect", open_flt, 1'b1);
        chk("R7", "fault at open", fault, 1'b1);
        chk("R7", "mask with open", gate_mask, 1'b1);
        drain_lo = 1'b0;
        step(1);
        chk("R9", "open after drain_lo low", open_flt, 1'b0);
        drain_lo = 1'b1;
        step(OF + 1);
        chk("R7", "open re-detect", open_flt, 1'b1);
        gate_cmd = 1'b1;
        step(1);
        chk("R8", "open cleared by gate on", open_flt, 1'b0);
        step(20);
        chk("R8", "no open while gate on", open_flt, 1'b0);
    endtask

    task automatic t_open_glitch();
        do_reset();
        gate_cmd = 1'b0; drain_lo = 1'b1;
        step(OF);
        drain_lo = 1'b0;
        step(1);
        drain_lo = 1'b1;
        step(OF);
        chk("R2", "open after broken run", open_flt, 1'b0);
        step(1);
        chk("R2", "open after full run", open_flt, 1'b1);
    endtask

    initial begin
        t_reset();
        t_short_retry();
        t_retry_exit();
        t_cmd_off_on();
        t_short_glitch();
        t_short_gate_off();
        t_open();
        t_open_glitch();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule